// File: doc/BRIEF.md
# Sound Channel Period Timer

This block sets the pitch of a sound channel. It is a programmable down counter that counts CPU clock enables. Each time the count passes through zero, the counter loads the programmed period again and drives a single-cycle tick. A waveform stage downstream advances on that tick. With period P, the block produces one tick every P+1 counting steps.

A build-time parameter selects one of two rates. At full rate, every CPU clock enable is a counting step. At half rate, a toggle stage lets only every second enable through, so the effective periods, measured in CPU cycles, are always even.

The period input can change at any time. A new value takes effect only at the next load. A force strobe loads the period at once and produces no tick.

Top module: `chan_period_timer`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `count` is 0 and `tick` is 0. The half-rate toggle stage is cleared, so the first enable after reset does not step the counter.
- R2: A counting step with `count` equal to 0 (and no force) loads `count` with `period`. `tick` is 1 on the next cycle only.
- R3: A counting step with `count` non-zero (and no force) lowers `count` by one. `tick` is 0 on the next cycle.
- R4: At full rate with `cpu_ce` held at 1 and period P, there is exactly one tick every P+1 cycles.
- R5: `reload_req` high loads `count` with `period` on that edge, whether or not `cpu_ce` is high. `tick` is 0 on the next cycle, even if that edge would also have been an expiry.
- R6: A change of `period` leaves the current `count` untouched. The new value is used only at the next load (expiry or force).
- R7: A cycle that has no counting step and no force keeps `count` unchanged and `tick` at 0.
- R8: At half rate, only every second `cpu_ce` pulse after reset is a counting step: the second, fourth, and so on. At full rate, every pulse is a counting step.
- R9: With `period` 0 at full rate and `cpu_ce` held at 1, `tick` stays at 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU clock enable, one pulse per CPU cycle |
| period | input | PERIOD_W (11) | Programmed period P |
| reload_req | input | 1 | Force an immediate load of the period, with no tick |
| tick | output | 1 | Single-cycle pulse on each expiry |
| count | output | PERIOD_W (11) | Current counter value |

## Verification
The hardest case to reach from the ports is a force that lands on the same edge as a natural expiry. In normal counting, that alignment happens only once every P+1 steps. The bench makes it happen on every cycle by setting the period to 0 at full rate with the enable held high. Every step is then an expiry, so a force asserted on any cycle must remove the tick that would otherwise follow. For the other collisions, random enables, forces and period changes run against a behavioural model, which is compared with both rate variants on every clock.

// File: rtl/chan_timer_pkg.sv
package chan_timer_pkg;
    localparam int unsigned CT_PERIOD_W = 11;

    typedef struct packed {
        logic [CT_PERIOD_W-1:0] cnt;
        logic                   tick;
    } ct_state_t;
endpackage

// File: rtl/chan_timer_prescale.sv
module chan_timer_prescale #(
    parameter bit HALF_RATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ce,
    output logic step
);
    generate
        if (HALF_RATE) begin : g_half
            logic phase_d, phase_q;

            always_comb begin
                phase_d = phase_q;
                if (cpu_ce) phase_d = ~phase_q;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) phase_q <= 1'b0;
                else        phase_q <= phase_d;
            end

            assign step = cpu_ce & phase_q;

            // R8: only every second enable passes
            p_alt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> !step);
            p_phase_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_ce |=> (phase_q != $past(phase_q)));
        end else begin : g_full
            assign step = cpu_ce;
        end
    endgenerate
endmodule

// File: rtl/chan_timer_core.sv
module chan_timer_core
    import chan_timer_pkg::*;
#(
    parameter int unsigned PERIOD_W = CT_PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                force_load,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] cnt,
    output logic                tick
);
    localparam logic [PERIOD_W-1:0] ZERO = '0;
    localparam logic [PERIOD_W-1:0] ONE  = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt_d, cnt_q;
    logic                tick_d, tick_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_d = 1'b0;
        if (force_load) begin
            cnt_d = period;
        end else if (step) begin
            if (cnt_q == ZERO) begin
                cnt_d  = period;
                tick_d = 1'b1;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign cnt  = cnt_q;
    assign tick = tick_q;

    p_expiry_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_load && cnt_q == ZERO) |=> (tick_q && cnt_q == $past(period)));
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_load && cnt_q != ZERO) |=> (!tick_q && cnt_q == $past(cnt_q) - ONE));
    p_force_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_load |=> (!tick_q && cnt_q == $past(period)));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_load) |=> (!tick_q && $stable(cnt_q)));
endmodule

// File: rtl/chan_period_timer.sv
module chan_period_timer
    import chan_timer_pkg::*;
#(
    parameter int unsigned PERIOD_W  = CT_PERIOD_W,
    parameter bit          HALF_RATE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_ce,
    input  logic [PERIOD_W-1:0] period,
    input  logic                reload_req,
    output logic                tick,
    output logic [PERIOD_W-1:0] count
);
    logic step;

    chan_timer_prescale #(.HALF_RATE(HALF_RATE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_ce (cpu_ce),
        .step   (step)
    );

    chan_timer_core #(.PERIOD_W(PERIOD_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .force_load (reload_req),
        .period     (period),
        .cnt        (count),
        .tick       (tick)
    );

    // R1: reset leaves the counter and tick cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !tick));
endmodule

// File: tb/chan_period_timer_tb.sv
module chan_period_timer_tb;
    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_ce = 1'b0;
    logic [W-1:0] period = '0;
    logic         reload_req = 1'b0;
    logic         tick_f, tick_h;
    logic [W-1:0] count_f, count_h;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    chan_period_timer #(.PERIOD_W(W), .HALF_RATE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .period(period),
        .reload_req(reload_req), .tick(tick_f), .count(count_f));

    chan_period_timer #(.PERIOD_W(W), .HALF_RATE(1'b1)) u_dut_half (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .period(period),
        .reload_req(reload_req), .tick(tick_h), .count(count_h));

    // behavioural reference: index 0 full rate, 1 half rate
    int m_cnt [2];
    int m_tick[2];
    int m_ph  [2];

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            bit stp;
            if (!rst_n) begin
                m_cnt[v] = 0; m_tick[v] = 0; m_ph[v] = 0;
            end else begin
                stp = cpu_ce && (v == 0 || m_ph[v] == 1);
                if (cpu_ce) m_ph[v] = 1 - m_ph[v];
                m_tick[v] = 0;
                if (reload_req) m_cnt[v] = int'(period);
                else if (stp) begin
                    if (m_cnt[v] == 0) begin
                        m_cnt[v] = int'(period); m_tick[v] = 1;
                    end else m_cnt[v] = m_cnt[v] - 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        check(cur_req, int'(count_f), m_cnt[0],  "full count");
        check(cur_req, int'(tick_f),  m_tick[0], "full tick");
        check(cur_req, int'(count_h), m_cnt[1],  "half count");
        check(cur_req, int'(tick_h),  m_tick[1], "half tick");
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ticks_f, ticks_h, c0;
        cyc(3);
        check("R1", int'(count_f) + int'(tick_f) + int'(count_h) + int'(tick_h), 0, "reset state");
        rst_n = 1'b1;
        cyc(1);
        check("R1", int'(count_f) + int'(tick_h), 0, "after release");

        // R8 first enables after reset
        cur_req = "R8";
        period = 11'd7; cpu_ce = 1'b1;
        cyc(1);
        check("R2", int'(tick_f), 1, "full first ce expiry tick");
        check("R2", int'(count_f), 7, "full first ce load");
        check("R8", int'(tick_h), 0, "half first ce no step");
        check("R8", int'(count_h), 0, "half first ce count");
        cpu_ce = 1'b0;
        cyc(1);
        check("R2", int'(tick_f), 0, "tick lasts one cycle");
        cpu_ce = 1'b1;
        cyc(1);
        check("R8", int'(tick_h), 1, "half second ce steps");
        check("R8", int'(count_h), 7, "half second ce load");
        check("R3", int'(count_f), 6, "full decrement");

        // R4 cadence
        cur_req = "R4";
        period = 11'd3; reload_req = 1'b1;
        cyc(1);
        reload_req = 1'b0;
        ticks_f = 0; ticks_h = 0;
        for (int i = 0; i < 41; i++) begin
            cyc(1);
            ticks_f += int'(tick_f);
            ticks_h += int'(tick_h);
        end
        check("R4", ticks_f, 10, "full tick count over 41 cycles");
        check("R8", ticks_h, 5, "half tick count over 41 cycles");

        // R9 and R5 collision with period 0
        cur_req = "R9";
        period = 11'd0;
        cyc(3);
        check("R9", int'(tick_f), 1, "period 0 continuous tick");
        cyc(1);
        check("R9", int'(tick_f), 1, "period 0 continuous tick");
        cur_req = "R5";
        reload_req = 1'b1;
        cyc(1);
        reload_req = 1'b0;
        check("R5", int'(tick_f), 0, "force beats expiry");
        cyc(1);
        check("R9", int'(tick_f), 1, "ticks resume");

        // R5 force without enable
        cpu_ce = 1'b0; period = 11'd9; reload_req = 1'b1;
        cyc(1);
        reload_req = 1'b0;
        check("R5", int'(count_f), 9, "force without ce");
        check("R5", int'(count_h), 9, "force without ce half");

        // R7 hold
        cur_req = "R7";
        c0 = int'(count_f);
        cyc(10);
        check("R7", int'(count_f), c0, "hold without ce");
        check("R7", int'(tick_f), 0, "no tick without ce");

        // R6 period change mid-count
        cur_req = "R6";
        period = 11'd5; reload_req = 1'b1;
        cyc(1);
        reload_req = 1'b0; cpu_ce = 1'b1;
        cyc(1);
        check("R3", int'(count_f), 4, "step from 5");
        period = 11'd2;
        cyc(1);
        check("R6", int'(count_f), 3, "count untouched by period change");
        cyc(4);
        check("R6", int'(count_f), 2, "new period used at reload");

        // random mix against model
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            cpu_ce = ($urandom_range(0, 3) != 0);
            reload_req = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 29) == 0) period = W'($urandom_range(0, 6));
            cyc(1);
        end
        cpu_ce = 1'b0; reload_req = 1'b0;
        cyc(2);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule